// File: doc/BRIEF.md
# Speculative four-pixel error-diffusion binarizer

This block turns a scan line of grey pixels into black and white dots by error diffusion. It takes four neighbouring pixels of a line as one group. It quantizes each pixel against mid-scale and passes the quantization error on to the pixels that follow. The sequential dependency, where each pixel needs the error of its left neighbour, would normally force one pixel per step. This block avoids that in two stages. A first stage filters the errors of the line above for all four lanes at once. It makes a speculative black/white decision with the left-neighbour term set to zero, except in lane 0, which already has the true carried error. For each lane it keeps an all-ones or all-zeros decision mask and two candidate errors, one for the speculative level and one for the opposite level. A second stage walks lanes 1 to 3 in order. It repairs each decision with the true error of its predecessor and selects the matching candidate. Only adds, shifts and compares are used, with no multiplier.

The caller supplies the four pixels, the six errors of the line above that the group touches, and flags for the first and last group of a line. The caller stores the four returned errors, which serve as the line-above errors of the next line. The block keeps the last error of each group internally and carries it into the next group. Both sides of the block use a valid/ready handshake.

Top module: `ed4_halftone`

## Requirements
- R1: After a clock edge with `rst_n` low, `out_valid` is 0 and `in_ready` is 1.
- R2: Pixel k of a group is in `in_pix[16k+15:16k]` as an unsigned value. Its modified input is U = 16·pixel − W, where W is the weighted neighbour sum of R4. Output bit k (`out_bits[k]`) is 1, meaning level 255, exactly when U ≥ 2048. Otherwise the bit is 0, meaning level 0.
- R3: The error of pixel k, in `out_err[16k+15:16k]` as a 16-bit two's complement value, is floor((16·q − U)/16), where q is 255 or 0 as decided in R2.
- R4: W = 7·(error of the left pixel) + 1·A[k] + 5·A[k+1] + 3·A[k+2]. A[i] is the signed 16-bit `in_above[16i+15:16i]` and is the line-above error at column (column of pixel 0) − 1 + i.
- R5: The left error used by pixels 1 to 3 is the final error of the pixel just before them in the same group. The results equal those of a strictly sequential pass, including cases where the zero-feedback guess was wrong.
- R6: The left error of pixel 0 is the error of pixel 3 of the previously accepted group.
- R7: When `in_first` is 1, the carried left error and A[0] are treated as zero, whatever their values.
- R8: When `in_last` is 1, A[5] is treated as zero, whatever its value.
- R9: A group is taken only at an edge where `in_valid` and `in_ready` are both 1. After it is taken, `in_ready` stays 0 until that group has moved to the output register, so at most one group is in the compute stage.
- R10: Groups leave in the order they were accepted. While `out_valid` is 1 and `out_ready` is 0, the output values hold. A group accepted while the output register is empty or being drained shows `out_valid` one edge after its acceptance edge.
- R11: Whenever `out_valid` is 1, a lane with bit 1 carries an error of at most 127, and a lane with bit 0 carries an error of at least −128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A group is presented |
| in_ready | output | 1 | The block can take a group |
| in_first | input | 1 | Group starts a line |
| in_last | input | 1 | Group ends a line |
| in_pix | input | 64 | Four unsigned pixels, lane k at bits 16k+15:16k |
| in_above | input | 96 | Six signed line-above errors, columns −1 to +4 relative to lane 0 |
| out_valid | output | 1 | A result group is held |
| out_ready | input | 1 | The consumer takes the result |
| out_bits | output | 4 | Binary pixels, 1 means level 255 |
| out_err | output | 64 | Four signed errors, lane k at bits 16k+15:16k |

## Verification
A wrong repair decision in lane 1, 2 or 3 shows up in the same result group: a flipped bit and an error that differs from the sequential reference. Because every later lane and the carried error build on it, one wrong lane corrupts the rest of the group and the first lane of the next group. A stale or badly reset carry register therefore shows up by the second group of a line. Handshake faults show up as a missing, duplicated or reordered group, or as output values changing under backpressure, within a cycle.

// File: rtl/ed4_pkg.sv
`timescale 1ns/1ps
// Shared constants for the speculative error-diffusion binarizer.
// Assumes fixed diffusion weights in sixteenths; the weights are applied
// with shift-and-add, and the final division by sixteen is a right shift.
package ed4_pkg;
    localparam int FRAC = 4;     // weights are in units of 1/16
    localparam int W_LEFT = 7;   // left neighbour, same line
    localparam int W_UL = 1;     // upper-left
    localparam int W_UP = 5;     // directly above
    localparam int W_UR = 3;     // upper-right
endpackage

// File: rtl/ed4_spec.sv
`timescale 1ns/1ps
// Speculative stage: filters line-above errors for every lane in parallel
// and decides each pixel with the left-neighbour term zeroed, except lane 0,
// which receives the true carried error. Emits the partial modified input,
// a 16-bit decision mask and two candidate errors (speculative level and
// opposite level), both kept at 1/16 precision so no multiply is needed later.
// Assumes AW is wide enough for 16*pixel plus the weighted sum.
module ed4_spec
    import ed4_pkg::*;
#(
    parameter int DW = 16,
    parameter int LANES = 4,
    parameter int AW = 24,
    parameter int THR = 128,
    parameter int QMAX = 255
) (
    input  logic [LANES*DW-1:0]     pix,
    input  logic [(LANES+2)*DW-1:0] above,
    input  logic [DW-1:0]           carry,
    input  logic                    first,
    input  logic                    last,
    output logic [LANES*AW-1:0]     pu,
    output logic [LANES*AW-1:0]     cand_s,
    output logic [LANES*AW-1:0]     cand_i,
    output logic [LANES*DW-1:0]     mask
);
    localparam int ALANES = LANES + 2;
    localparam logic signed [AW-1:0] THR16 = AW'(THR << FRAC);
    localparam logic signed [AW-1:0] QMAX16 = AW'(QMAX << FRAC);

    logic [DW-1:0] a [ALANES];
    logic [DW-1:0] carry_eff;

    // Edge handling: zero the line-above errors outside the image and the carry at line start.
    always_comb begin
        for (int i = 0; i < ALANES; i++) a[i] = above[i*DW +: DW];
        if (first) a[0] = '0;
        if (last) a[ALANES-1] = '0;
        carry_eff = first ? '0 : carry;
    end

    for (genvar k = 0; k < LANES; k++) begin : gen_lane
        logic signed [AW-1:0] ul, up, ur, lf, xs, w, p;
        logic d;
        // Per-lane weighted sum, partial modified input and speculative decision.
        always_comb begin
            ul = {{(AW-DW){a[k][DW-1]}}, a[k]};
            up = {{(AW-DW){a[k+1][DW-1]}}, a[k+1]};
            ur = {{(AW-DW){a[k+2][DW-1]}}, a[k+2]};
            lf = (k == 0) ? {{(AW-DW){carry_eff[DW-1]}}, carry_eff} : '0;
            xs = {{(AW-DW){1'b0}}, pix[k*DW +: DW]};
            w  = ul + (up <<< 2) + up + (ur <<< 1) + ur + (lf <<< 3) - lf;
            p  = (xs <<< FRAC) - w;
            d  = (p >= THR16);
        end
        assign pu[k*AW +: AW]     = p;
        assign mask[k*DW +: DW]   = {DW{d}};
        assign cand_s[k*AW +: AW] = (d ? QMAX16 : '0) - p;
        assign cand_i[k*AW +: AW] = (d ? '0 : QMAX16) - p;
    end
endmodule

// File: rtl/ed4_comp.sv
`timescale 1ns/1ps
// Compensation stage: lane 0 is final as speculated; lanes 1..LANES-1 are
// repaired strictly in order. Each lane re-tests its threshold with seven
// times the predecessor's final error subtracted, picks the candidate error
// that matches the repaired decision, adds the predecessor term back and
// divides by sixteen (floor). Purely combinational.
module ed4_comp
    import ed4_pkg::*;
#(
    parameter int DW = 16,
    parameter int LANES = 4,
    parameter int AW = 24,
    parameter int THR = 128
) (
    input  logic [LANES*AW-1:0] pu,
    input  logic [LANES*AW-1:0] cand_s,
    input  logic [LANES*AW-1:0] cand_i,
    input  logic [LANES*DW-1:0] mask,
    output logic [LANES-1:0]    bits,
    output logic [LANES*DW-1:0] err
);
    localparam logic signed [AW-1:0] THR16 = AW'(THR << FRAC);

    for (genvar k = 0; k < LANES; k++) begin : gen_lane
        logic [DW-1:0] e_lane;
        logic          b_lane;
        if (k == 0) begin : g_first
            logic [AW-1:0] full;
            // First lane: the speculative result is already exact.
            always_comb begin
                full   = cand_s[0 +: AW];
                e_lane = full[FRAC +: DW];
                b_lane = mask[0];
            end
        end else begin : g_rest
            logic signed [AW-1:0] pe, prev7, t, full;
            logic d, hold;
            // Repair this lane using the final error of the lane before it.
            always_comb begin
                pe     = {{(AW-DW){gen_lane[k-1].e_lane[DW-1]}}, gen_lane[k-1].e_lane};
                prev7  = (pe <<< 3) - pe;
                t      = $signed(pu[k*AW +: AW]) - prev7;
                d      = (t >= THR16);
                hold   = (d == mask[k*DW]);
                full   = (hold ? $signed(cand_s[k*AW +: AW]) : $signed(cand_i[k*AW +: AW])) + prev7;
                e_lane = full[FRAC +: DW];
                b_lane = d;
            end
        end
        assign err[k*DW +: DW] = e_lane;
        assign bits[k] = b_lane;
    end
endmodule

// File: rtl/ed4_halftone.sv
`timescale 1ns/1ps
// Top of the speculative four-pixel error-diffusion binarizer.
// Stage 1 registers the speculative results; stage 2 is the output register,
// loaded with the compensated results. A group is accepted only while stage 1
// is empty, so the carried error of the previous group is always settled.
// Assumes the caller stores out_err and supplies it as in_above on the next line.
module ed4_halftone #(
    parameter int DW = 16,
    parameter int LANES = 4,
    parameter int THR = 128,
    parameter int QMAX = 255
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    in_first,
    input  logic                    in_last,
    input  logic [LANES*DW-1:0]     in_pix,
    input  logic [(LANES+2)*DW-1:0] in_above,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [LANES-1:0]        out_bits,
    output logic [LANES*DW-1:0]     out_err
);
    localparam int AW = DW + 8;
    localparam logic signed [DW-1:0] ERR_HI = DW'(QMAX - THR);
    localparam logic signed [DW-1:0] ERR_LO = DW'(-THR);

    logic                  s1_valid;
    logic [LANES*AW-1:0]   s1_pu, s1_cs, s1_ci, sp_pu, sp_cs, sp_ci;
    logic [LANES*DW-1:0]   s1_mask, sp_mask, c_err;
    logic [LANES-1:0]      c_bits;
    logic [DW-1:0]         carry;
    logic                  accept, advance;

    ed4_spec #(.DW(DW), .LANES(LANES), .AW(AW), .THR(THR), .QMAX(QMAX)) i_spec (
        .pix(in_pix), .above(in_above), .carry(carry), .first(in_first), .last(in_last),
        .pu(sp_pu), .cand_s(sp_cs), .cand_i(sp_ci), .mask(sp_mask)
    );

    ed4_comp #(.DW(DW), .LANES(LANES), .AW(AW), .THR(THR)) i_comp (
        .pu(s1_pu), .cand_s(s1_cs), .cand_i(s1_ci), .mask(s1_mask),
        .bits(c_bits), .err(c_err)
    );

    assign in_ready = !s1_valid;
    assign accept   = in_valid && in_ready;
    assign advance  = s1_valid && (!out_valid || out_ready);

    // Stage 1 occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n)       s1_valid <= 1'b0;
        else if (accept)  s1_valid <= 1'b1;
        else if (advance) s1_valid <= 1'b0;
    end

    // Stage 1 data capture from the speculative stage.
    always_ff @(posedge clk) begin
        if (accept) begin
            s1_pu   <= sp_pu;
            s1_cs   <= sp_cs;
            s1_ci   <= sp_ci;
            s1_mask <= sp_mask;
        end
    end

    // Output register occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n)         out_valid <= 1'b0;
        else if (advance)   out_valid <= 1'b1;
        else if (out_ready) out_valid <= 1'b0;
    end

    // Output data and carried error, both taken from the compensated results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry <= '0;
        end else if (advance) begin
            out_bits <= c_bits;
            out_err  <= c_err;
            carry    <= c_err[(LANES-1)*DW +: DW];
        end
    end

    // R1: reset empties both stages.
    a_r1_reset: assert property (@(posedge clk) !rst_n |=> !out_valid && in_ready);

    // R9: an accepted group blocks the input on the next cycle.
    a_r9_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R10: held outputs stay stable under backpressure.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_bits) && $stable(out_err));

    // R10: a group accepted into a free pipe appears one edge later.
    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (!out_valid || out_ready)) |=> ##1 out_valid);

    for (genvar k = 0; k < LANES; k++) begin : g_chk
        // R11: error range matches the chosen level.
        a_r11_err_bound: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_bits[k] ? ($signed(out_err[k*DW +: DW]) <= ERR_HI)
                                       : ($signed(out_err[k*DW +: DW]) >= ERR_LO)));
    end
endmodule

// File: tb/test_ed4_halftone.sv
`timescale 1ns/1ps
module test_ed4_halftone;
    logic clk = 0, rst_n = 0, in_valid = 0, in_first = 0, in_last = 0, out_ready = 1;
    logic in_ready, out_valid;
    logic [3:0]  out_bits;
    logic [63:0] in_pix = '0, out_err;
    logic [95:0] in_above = '0;

    int n_tests = 0, n_fail = 0, cyc = 0, m_carry = 0;
    bit bp_mode = 0, seen = 0;
    int qb[$]; logic [63:0] qe[$]; string qt[$]; int qacc[$]; bit qlat[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ed4_halftone i_ed4_halftone (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_first(in_first), .in_last(in_last), .in_pix(in_pix), .in_above(in_above),
        .out_valid(out_valid), .out_ready(out_ready), .out_bits(out_bits), .out_err(out_err)
    );

    // Consumer: backpressure pattern applied just after each edge.
    always @(posedge clk) begin
        #1 out_ready <= bp_mode ? ($urandom_range(2) != 0) : 1'b1;
    end

    // Sequential reference of one group; pushes expected results.
    task automatic model(input int px[4], input int ab[6], input bit first, input bit last,
                         input string tag, input bit lat);
        int a[6]; int left, w, u, q, e, b; logic [63:0] ev;
        a = ab;
        if (first) a[0] = 0;
        if (last) a[5] = 0;
        left = first ? 0 : m_carry;
        b = 0; ev = '0;
        for (int k = 0; k < 4; k++) begin
            w = 7*left + a[k] + 5*a[k+1] + 3*a[k+2];
            u = 16*px[k] - w;
            q = (u >= 2048) ? 255 : 0;
            e = (16*q - u) >>> 4;
            if (q != 0) b = b | (1 << k);
            ev[k*16 +: 16] = 16'(e);
            left = e;
        end
        m_carry = left;
        qb.push_back(b); qe.push_back(ev); qt.push_back(tag);
        qacc.push_back(cyc); qlat.push_back(lat);
    endtask

    task automatic send(input int px[4], input int ab[6], input bit first, input bit last,
                        input string tag, input bit lat);
        @(negedge clk);
        for (int k = 0; k < 4; k++) in_pix[k*16 +: 16] = 16'(px[k]);
        for (int i = 0; i < 6; i++) in_above[i*16 +: 16] = 16'(ab[i]);
        in_first = first; in_last = last; in_valid = 1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        model(px, ab, first, last, tag, lat);
        in_valid = 0;
        n_tests++;
        if (in_ready !== 1'b0) begin
            n_fail++; $display("FAIL R9: in_ready after accept got %0b exp 0", in_ready);
        end
    endtask

    // Output comparison on every falling edge.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_tests++;
            if (qb.size() == 0) begin
                n_fail++; $display("FAIL R10: unexpected output group got 1 exp 0");
            end else begin
                if (out_bits !== 4'(qb[0])) begin
                    n_fail++;
                    $display("FAIL R2 (%s): bits got %b exp %b", qt[0], out_bits, 4'(qb[0]));
                end
                for (int k = 0; k < 4; k++) begin
                    n_tests++;
                    if (out_err[k*16 +: 16] !== qe[0][k*16 +: 16]) begin
                        n_fail++;
                        $display("FAIL R3 (%s): lane %0d err got %0d exp %0d", qt[0], k,
                                 $signed(out_err[k*16 +: 16]), $signed(qe[0][k*16 +: 16]));
                    end
                    n_tests++;
                    if (out_bits[k] ? ($signed(out_err[k*16 +: 16]) > 127)
                                    : ($signed(out_err[k*16 +: 16]) < -128)) begin
                        n_fail++;
                        $display("FAIL R11: lane %0d err got %0d exp within level range", k,
                                 $signed(out_err[k*16 +: 16]));
                    end
                end
                if (!seen) begin
                    seen = 1;
                    if (qlat[0]) begin
                        n_tests++;
                        if (cyc - qacc[0] != 1) begin
                            n_fail++;
                            $display("FAIL R10: latency got %0d exp 1", cyc - qacc[0]);
                        end
                    end
                end
                if (out_ready) begin
                    void'(qb.pop_front()); void'(qe.pop_front()); void'(qt.pop_front());
                    void'(qacc.pop_front()); void'(qlat.pop_front());
                    seen = 0;
                end
            end
        end
    end

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int px[4]; int ab[6]; int z[6];
        z = '{0, 0, 0, 0, 0, 0};
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            n_fail++; $display("FAIL R1: out_valid/in_ready got %b%b exp 01", out_valid, in_ready);
        end
        rst_n = 1;

        px = '{200, 40, 130, 10};   send(px, z, 1, 0, "R2", 1);
        px = '{128, 128, 128, 128}; send(px, z, 1, 0, "R5", 1);
        px = '{100, 100, 100, 100}; send(px, z, 0, 0, "R6", 1);
        px = '{90, 170, 60, 140};
        ab = '{-40, 30, -10, 60, -70, 20}; send(px, ab, 0, 0, "R4", 1);
        // R7: a large carry and A[0] must both be ignored at line start.
        px = '{128, 20, 240, 128};
        ab = '{100, 0, 0, 0, 0, 0}; send(px, ab, 1, 0, "R7", 1);
        // R8: A[5] must be ignored at the line end.
        px = '{128, 128, 128, 128};
        ab = '{0, 0, 0, 0, 0, 100}; send(px, ab, 0, 1, "R8", 1);

        // Random lines under backpressure: ordering and hold (R10), chaining (R5, R6).
        bp_mode = 1;
        for (int ln = 0; ln < 25; ln++) begin
            for (int g = 0; g < 8; g++) begin
                for (int k = 0; k < 4; k++) px[k] = $urandom_range(255);
                for (int i = 0; i < 6; i++) ab[i] = $urandom_range(255) - 128;
                send(px, ab, g == 0, g == 7, "R10", 0);
            end
        end
        bp_mode = 0;
        while (qb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule